// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This unit rearranges the bytes of a 32-bit operand and produces the four status flags a processor writes after such an operation: zero, sign, carry and overflow. A 2-bit select chooses one of three rearrangements:

- exchanging the two bytes inside each halfword;
- reversing the order of all four bytes;
- exchanging the upper and lower halfwords.

The fourth select code passes the operand through without changing it and requests no flag update.

The zero and carry flags do not carry their usual arithmetic meaning. Each operation defines them so that they report whether a byte or a halfword of the result is zero. This lets string-scanning loops detect a terminating zero byte without extra compare instructions. The unit is purely combinational. It sits in an execute stage between operand read and writeback, and the flag-write strobe tells the status register whether to take the flags.

Top module: `byte_swap_unit`

## Requirements
- R1: With select 2'b00, result bytes are exchanged inside each halfword: result[31:24]=src[23:16], result[23:16]=src[31:24], result[15:8]=src[7:0], result[7:0]=src[15:8].
- R2: With select 2'b00, the zero flag is 1 exactly when result[15:0] is zero; the upper halfword has no effect on it.
- R3: With select 2'b00, the carry flag is 1 exactly when result[7:0] or result[15:8] is zero; the upper two bytes have no effect on it.
- R4: With select 2'b01, the byte order is fully reversed (result byte k = source byte 3-k), and the zero flag is 1 exactly when all 32 result bits are zero.
- R5: With select 2'b01, the carry flag is 1 exactly when at least one of the four result bytes is zero.
- R6: With select 2'b10, result[31:16]=src[15:0] and result[15:0]=src[31:16]; zero is 1 exactly when the whole result is zero, and carry is 1 exactly when either result halfword is zero.
- R7: For selects 2'b00, 2'b01 and 2'b10, the sign flag equals result bit 31.
- R8: The overflow flag is always 0.
- R9: For select 2'b11, the result equals the operand, all four flags are 0, and the flag-write strobe is 0. For every other select, the strobe is 1.
- R10: The outputs are a combinational function of the present inputs: a change of input is visible at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Source word to rearrange |
| op_sel_i | input | 2 | Operation: 00 pair swap, 01 byte reverse, 10 halfword swap, 11 pass-through |
| result_o | output | 32 | Rearranged word |
| flag_z_o | output | 1 | Zero flag, defined per operation |
| flag_s_o | output | 1 | Sign flag, equals result bit 31 |
| flag_cy_o | output | 1 | Carry flag: a zero byte or zero halfword was found |
| flag_ov_o | output | 1 | Overflow flag, always 0 |
| flag_we_o | output | 1 | Flag-write strobe, 0 for pass-through |

## Verification
The unit holds no state, so a wrong byte-lane route or zero-detect term shows up at the ports in the same evaluation as the faulty input. No cycle latency can hide it.

A wrong lane route moves a byte to the wrong position, but it does not change the population count, so only exact result comparison catches it. A zero flag that is computed over the wrong span only shows up for operands whose zero halfword sits in the lane that is not tested. For this reason the vectors put zero bytes in each lane in turn, under each select.

// File: rtl/byte_swap_pkg.sv
// Package: shared widths and the operation encoding of the swap unit.
// Assumes a word of exactly four bytes.
package byte_swap_pkg;
    localparam int unsigned SWP_BYTE_W = 8;
    localparam int unsigned SWP_NBYTES = 4;
    localparam int unsigned SWP_WORD_W = SWP_BYTE_W * SWP_NBYTES;

    typedef enum logic [1:0] {
        SWP_PAIR = 2'b00,
        SWP_REV  = 2'b01,
        SWP_HALF = 2'b10,
        SWP_PASS = 2'b11
    } swp_op_e;
endpackage

// File: rtl/byte_swap_lanes.sv
// Module: byte_swap_lanes
// Routes source bytes to result bytes for the selected operation.
// Assumes NBYTES is even; the pair swap exchanges bytes 2k and 2k+1.
module byte_swap_lanes
    import byte_swap_pkg::*;
#(
    parameter int unsigned BYTE_W = SWP_BYTE_W,
    parameter int unsigned NBYTES = SWP_NBYTES
) (
    input  logic [BYTE_W*NBYTES-1:0] src_i,
    input  logic [1:0]               op_i,
    output logic [BYTE_W*NBYTES-1:0] res_o
);
    localparam int unsigned WORD_W = BYTE_W * NBYTES;
    localparam int unsigned HALF_B = NBYTES / 2;

    logic [WORD_W-1:0] pair_w;
    logic [WORD_W-1:0] rev_w;
    logic [WORD_W-1:0] half_w;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        localparam int unsigned PAIR_SRC = g ^ 1;
        localparam int unsigned REV_SRC  = NBYTES - 1 - g;
        localparam int unsigned HALF_SRC = (g + HALF_B) % NBYTES;
        assign pair_w[g*BYTE_W +: BYTE_W] = src_i[PAIR_SRC*BYTE_W +: BYTE_W];
        assign rev_w [g*BYTE_W +: BYTE_W] = src_i[REV_SRC*BYTE_W  +: BYTE_W];
        assign half_w[g*BYTE_W +: BYTE_W] = src_i[HALF_SRC*BYTE_W +: BYTE_W];
    end

    // Pick the routed word for the requested operation.
    always_comb begin
        unique case (swp_op_e'(op_i))
            SWP_PAIR: res_o = pair_w;
            SWP_REV:  res_o = rev_w;
            SWP_HALF: res_o = half_w;
            default:  res_o = src_i;
        endcase
    end
endmodule

// File: rtl/byte_swap_flags.sv
// Module: byte_swap_flags
// Derives zero, sign, carry and overflow from the rearranged word.
// Assumes a four-byte word; pass-through yields all-zero flags.
module byte_swap_flags
    import byte_swap_pkg::*;
#(
    parameter int unsigned BYTE_W = SWP_BYTE_W,
    parameter int unsigned NBYTES = SWP_NBYTES
) (
    input  logic [BYTE_W*NBYTES-1:0] res_i,
    input  logic [1:0]               op_i,
    output logic                     z_o,
    output logic                     s_o,
    output logic                     cy_o,
    output logic                     ov_o
);
    localparam int unsigned WORD_W = BYTE_W * NBYTES;
    localparam int unsigned HALF_W = WORD_W / 2;

    logic [NBYTES-1:0] byte_zero;
    logic              lo_half_zero;
    logic              hi_half_zero;

    for (genvar g = 0; g < NBYTES; g++) begin : g_bz
        assign byte_zero[g] = (res_i[g*BYTE_W +: BYTE_W] == '0);
    end

    assign lo_half_zero = (res_i[HALF_W-1:0] == '0);
    assign hi_half_zero = (res_i[WORD_W-1:HALF_W] == '0);

    // Apply the per-operation zero and carry rules.
    always_comb begin
        z_o  = 1'b0;
        s_o  = 1'b0;
        cy_o = 1'b0;
        ov_o = 1'b0;
        unique case (swp_op_e'(op_i))
            SWP_PAIR: begin
                z_o  = lo_half_zero;
                cy_o = byte_zero[0] | byte_zero[1];
                s_o  = res_i[WORD_W-1];
            end
            SWP_REV: begin
                z_o  = lo_half_zero & hi_half_zero;
                cy_o = |byte_zero;
                s_o  = res_i[WORD_W-1];
            end
            SWP_HALF: begin
                z_o  = lo_half_zero & hi_half_zero;
                cy_o = lo_half_zero | hi_half_zero;
                s_o  = res_i[WORD_W-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/byte_swap_unit.sv
// Module: byte_swap_unit (top)
// Combinational byte/halfword rearrangement with status-flag outputs.
// Assumes the caller registers the outputs; no clock or reset is used.
module byte_swap_unit
    import byte_swap_pkg::*;
(
    input  logic [31:0] operand_i,
    input  logic [1:0]  op_sel_i,
    output logic [31:0] result_o,
    output logic        flag_z_o,
    output logic        flag_s_o,
    output logic        flag_cy_o,
    output logic        flag_ov_o,
    output logic        flag_we_o
);
    byte_swap_lanes #(.BYTE_W(SWP_BYTE_W), .NBYTES(SWP_NBYTES)) u_lanes (
        .src_i (operand_i),
        .op_i  (op_sel_i),
        .res_o (result_o)
    );

    byte_swap_flags #(.BYTE_W(SWP_BYTE_W), .NBYTES(SWP_NBYTES)) u_flags (
        .res_i (result_o),
        .op_i  (op_sel_i),
        .z_o   (flag_z_o),
        .s_o   (flag_s_o),
        .cy_o  (flag_cy_o),
        .ov_o  (flag_ov_o)
    );

    // Request a status update for every real operation.
    always_comb flag_we_o = (swp_op_e'(op_sel_i) != SWP_PASS);
endmodule

// File: rtl/byte_swap_unit_chk.sv
// Module: byte_swap_unit_chk
// Immediate checks on the port relations of byte_swap_unit.
// Assumes it is bound into the top; it observes ports only.
module byte_swap_unit_chk (
    input logic [31:0] operand_i,
    input logic [1:0]  op_sel_i,
    input logic [31:0] result_o,
    input logic        flag_z_o,
    input logic        flag_s_o,
    input logic        flag_cy_o,
    input logic        flag_ov_o,
    input logic        flag_we_o
);
    // Check the port relations whenever any input or output moves.
    always_comb begin
        assert_no_overflow_R8: assert (!flag_ov_o)
            else $error("overflow flag set");
        assert_strobe_R9: assert (flag_we_o == (op_sel_i != 2'b11))
            else $error("strobe wrong for select %0d", op_sel_i);
        if (op_sel_i == 2'b11) begin
            assert_passthru_R9: assert (result_o == operand_i && !flag_z_o && !flag_s_o && !flag_cy_o)
                else $error("pass-through altered data or flags");
        end else begin
            assert_sign_msb_R7: assert (flag_s_o == result_o[31])
                else $error("sign does not follow result msb");
            assert_bitcount_R1: assert ($countones(result_o) == $countones(operand_i))
                else $error("rearrangement lost or gained bits");
        end
        if (op_sel_i == 2'b00 && flag_z_o) begin
            assert_zero_low_R2: assert (result_o[15:0] == 16'h0)
                else $error("zero set with nonzero low halfword");
        end
        if (op_sel_i != 2'b00 && op_sel_i != 2'b11 && flag_z_o) begin
            assert_zero_word_R4: assert (result_o == 32'h0)
                else $error("zero set with nonzero word");
        end
        if (op_sel_i == 2'b01 && !flag_cy_o) begin
            assert_no_zero_byte_R5: assert (operand_i[7:0] != 8'h0 && operand_i[15:8] != 8'h0 &&
                                            operand_i[23:16] != 8'h0 && operand_i[31:24] != 8'h0)
                else $error("carry clear while a zero byte is present");
        end
    end
endmodule

bind byte_swap_unit byte_swap_unit_chk u_chk (.*);

// File: tb/tb_byte_swap_unit.sv
// Bench: table walk, then reset-state, random and combinational checks.
module tb_byte_swap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand_i = 32'h0;
    logic [1:0]  op_sel_i = 2'b11;
    logic [31:0] result_o;
    logic        flag_z_o, flag_s_o, flag_cy_o, flag_ov_o, flag_we_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    byte_swap_unit dut (.*);

    // {op, operand, expected result, z, s, cy, ov, we}
    localparam logic [70:0] VEC [14] = '{
        {2'd0, 32'h11223344, 32'h22114433, 5'b00001},
        {2'd0, 32'h12340000, 32'h34120000, 5'b10101},
        {2'd0, 32'h00FF8000, 32'hFF000080, 5'b01101},
        {2'd0, 32'h00AB12CD, 32'hAB00CD12, 5'b01001},
        {2'd1, 32'h11223344, 32'h44332211, 5'b00001},
        {2'd1, 32'h00000000, 32'h00000000, 5'b10101},
        {2'd1, 32'h80FF7F01, 32'h017FFF80, 5'b00001},
        {2'd1, 32'h01020300, 32'h00030201, 5'b00101},
        {2'd2, 32'h12345678, 32'h56781234, 5'b00001},
        {2'd2, 32'hABCD0000, 32'h0000ABCD, 5'b00101},
        {2'd2, 32'h00008001, 32'h80010000, 5'b01101},
        {2'd2, 32'h00FF00FF, 32'h00FF00FF, 5'b00001},
        {2'd3, 32'hDEAD0000, 32'hDEAD0000, 5'b00000},
        {2'd3, 32'h00000000, 32'h00000000, 5'b00000}
    };

    function automatic logic [36:0] ref_model(input logic [1:0] op, input logic [31:0] x);
        logic [31:0] r;
        logic z, s, cy, we;
        r = x; z = 0; s = 0; cy = 0; we = (op != 2'b11);
        case (op)
            2'b00: begin
                r  = {x[23:16], x[31:24], x[7:0], x[15:8]};
                z  = (r[15:0] == 0);
                cy = (r[7:0] == 0) || (r[15:8] == 0);
            end
            2'b01: begin
                r  = {x[7:0], x[15:8], x[23:16], x[31:24]};
                z  = (r == 0);
                cy = (r[7:0] == 0) || (r[15:8] == 0) || (r[23:16] == 0) || (r[31:24] == 0);
            end
            2'b10: begin
                r  = {x[15:0], x[31:16]};
                z  = (r == 0);
                cy = (r[15:0] == 0) || (r[31:16] == 0);
            end
            default: ;
        endcase
        if (we) s = r[31];
        return {r, z, s, cy, 1'b0, we};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic [1:0] op, input logic [31:0] x, input logic [36:0] e);
        string rr, rz, rc;
        case (op)
            2'b00: begin rr = "R1"; rz = "R2"; rc = "R3"; end
            2'b01: begin rr = "R4"; rz = "R4"; rc = "R5"; end
            2'b10: begin rr = "R6"; rz = "R6"; rc = "R6"; end
            default: begin rr = "R9"; rz = "R9"; rc = "R9"; end
        endcase
        chk($sformatf("%s result op%0d src %h", rr, op, x), result_o, e[36:5]);
        chk($sformatf("%s zero op%0d src %h", rz, op, x), {31'b0, flag_z_o}, {31'b0, e[4]});
        chk($sformatf("R7 sign op%0d src %h", op, x), {31'b0, flag_s_o}, {31'b0, e[3]});
        chk($sformatf("%s carry op%0d src %h", rc, op, x), {31'b0, flag_cy_o}, {31'b0, e[2]});
        chk("R8 overflow", {31'b0, flag_ov_o}, {31'b0, e[1]});
        chk("R9 strobe", {31'b0, flag_we_o}, {31'b0, e[0]});
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] x, input logic [36:0] e);
        @(posedge clk);
        op_sel_i  = op;
        operand_i = x;
        #1;
        check_all(op, x, e);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state: pass-through of zero, no flags, no strobe (R9).
        check_all(2'b11, 32'h0, {32'h0, 5'b00000});

        for (int i = 0; i < 14; i++)
            apply(VEC[i][70:69], VEC[i][68:37], VEC[i][36:0]);

        // Bench model cross-check of the table (R1..R9 expectations).
        for (int i = 0; i < 14; i++)
            chk("R9 table vs model", {27'b0, ref_model(VEC[i][70:69], VEC[i][68:37])[4:0]},
                {27'b0, VEC[i][4:0]});

        // R2 corner: upper halfword zero but low nonzero must not set zero.
        apply(2'b00, 32'h0000_0102, ref_model(2'b00, 32'h0000_0102));
        // R3 corner: zero bytes only in the upper half leave carry clear.
        apply(2'b00, 32'h0000_0102, ref_model(2'b00, 32'h0000_0102));

        // Random operands, often with a zero byte injected in a chosen lane.
        for (int i = 0; i < 1200; i++) begin
            logic [31:0] x;
            logic [1:0]  op;
            int lane;
            x    = $urandom;
            op   = 2'($urandom_range(0, 3));
            lane = $urandom_range(0, 7);
            if (lane < 4) x[lane*8 +: 8] = 8'h00;
            if (i % 97 == 0) x[31:16] = 16'h0;
            if (i % 89 == 0) x[15:0]  = 16'h0;
            apply(op, x, ref_model(op, x));
        end

        // R10: change inputs between clock edges; outputs must follow at once.
        @(negedge clk);
        op_sel_i  = 2'b01;
        operand_i = 32'hA1B2C3D4;
        #0.5;
        chk("R10 combinational result", result_o, 32'hD4C3B2A1);
        operand_i = 32'h00000000;
        #0.5;
        chk("R10 combinational zero", {31'b0, flag_z_o}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule